// File: doc/BRIEF.md
# Compare Event Timer

This block is a 24-bit event counter with a small register file. Software sets a start value N and a match value M, picks a count source, and sets the run bit. The counter then starts at N and advances by one for each source event. When an event arrives while the counter equals M, the block sets a match flag and restarts from N. When an event arrives while the counter holds its all-ones value, the counter wraps to zero and the block sets a wrap flag. The match flag is therefore set on event number M − N + 1, counted from the start value.

The count source is one of three. The first is an internal tick that gives one event every second clock. The second is the rising edge of an external pin, taken through a two-stage synchronizer. The third is a tick pulse from an external prescaler. Each flag clears when software writes a one to it, when its interrupt is acknowledged, and when the run bit is cleared. Each interrupt line is high while its flag and its enable bit are both set.

Sequencing is handled by a three-state machine. IDLE waits for the run bit; the IDLE→LOAD transition happens on the first clock that sees run set. LOAD copies N into the counter and takes the LOAD→RUN transition. RUN counts events; in RUN, a match causes the reload transition RUN→RUN, and a clear run bit causes the RUN→IDLE transition. A clear run bit in LOAD causes the LOAD→IDLE transition.

Top module: `evt_cmp_timer`

## Requirements
- R1: After reset, every readable register returns 0, the machine is in IDLE and both interrupt outputs are low.
- R2: A write that sets the run bit (control bit 0) moves IDLE→LOAD at the next clock and LOAD→RUN at the clock after that, and the counter holds N once LOAD→RUN is taken. With the internal source, the first event is counted on the second clock after the counter is loaded, and one further event is counted every second clock after that.
- R3: In RUN, an event that arrives while the counter equals M sets the match flag (control bit 21) and reloads N. The flag is therefore set on event number M − N + 1.
- R4: In RUN, an event that arrives while the counter is 0xFFFFFF and not equal to M sets the wrap flag (control bit 20) and loads 0 into the counter.
- R5: Writing 1 to a flag bit in the control register clears that flag. Writing 0 to a flag bit leaves it unchanged.
- R6: A one-cycle pulse on cmp_ack clears the match flag. A one-cycle pulse on ovf_ack clears the wrap flag.
- R7: Both flags read 0 from the clock that clears the run bit onward, for as long as the run bit stays clear.
- R8: If a hardware set and a clear of the same flag fall in the same cycle, the flag ends up set.
- R9: cmp_irq equals the match flag AND the match interrupt enable (bit 2). ovf_irq equals the wrap flag AND the wrap interrupt enable (bit 1).
- R10: When bit 15 is set, only pre_tick pulses are counted. When bit 15 is clear and bit 3 is set, each rising edge of ext_pin is counted once, on the third clock after the pin is sampled high. When both bits are clear, the internal tick is counted.
- R11: Control bits 23–22, 19–16 and every bit not named here read as 0, and writes to them have no effect.
- R12: The register addresses are: control at 0, start value N at 1, match value M at 2, and the counter at 3. The counter is read-only, and a write to address 3 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 24 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 24 | Read data (combinational) |
| ext_pin | input | 1 | External count pin (asynchronous) |
| pre_tick | input | 1 | Prescaler tick pulse |
| cmp_ack | input | 1 | Match interrupt acknowledge |
| ovf_ack | input | 1 | Wrap interrupt acknowledge |
| cmp_irq | output | 1 | Match interrupt request |
| ovf_irq | output | 1 | Wrap interrupt request |

## Verification
The internal source is run with N below M, and the exact clock on which the match flag rises shows whether the count uses M − N + 1 events and whether the reload goes back to N rather than to zero. Prescaler ticks with a start value just below all-ones separate the wrap path from the match path. A match tick placed in the same cycle as an acknowledge shows which of set and clear wins. External pin pulses held high for several clocks show that only rising edges are counted and that the prescaler select overrides the pin. A behavioural model updated on every clock checks the interrupt lines and the selected read register throughout all of these runs.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int REG_W  = 24;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_LOAD = 2'd1;
    localparam logic [ADDR_W-1:0] A_CMP  = 2'd2;
    localparam logic [ADDR_W-1:0] A_CNT  = 2'd3;

    localparam int B_RUN    = 0;
    localparam int B_OVF_IE = 1;
    localparam int B_CMP_IE = 2;
    localparam int B_EXT    = 3;
    localparam int B_PRE    = 15;
    localparam int B_OVF    = 20;
    localparam int B_CMP    = 21;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } cnt_st_e;
endpackage

// File: rtl/tmr_evt_src.sv
module tmr_evt_src #(
    parameter int SYNC_ST = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic use_pre,
    input  logic use_ext,
    input  logic ext_pin,
    input  logic pre_tick,
    output logic evt
);
    logic [SYNC_ST:0] sh;
    logic             half;
    logic             ext_evt;

    // synchronizer plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[SYNC_ST-1:0], ext_pin};
    end

    // half-rate internal tick, parked low while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run) half <= 1'b0;
        else                half <= ~half;
    end

    assign ext_evt = sh[SYNC_ST-1] & ~sh[SYNC_ST];

    always_comb begin
        if (use_pre)      evt = pre_tick;
        else if (use_ext) evt = ext_evt;
        else              evt = half;
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             evt,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt,
    output logic             cmp_hit,
    output logic             ovf_hit,
    output cnt_st_e          state
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    cnt_st_e          st_nxt;
    logic [CNT_W-1:0] cnt_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= st_nxt;
    end

    always_comb begin
        st_nxt = state;
        unique case (state)
            ST_IDLE: st_nxt = run ? ST_LOAD : ST_IDLE;
            ST_LOAD: st_nxt = run ? ST_RUN  : ST_IDLE;
            ST_RUN:  st_nxt = run ? ST_RUN  : ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        cmp_hit = 1'b0;
        ovf_hit = 1'b0;
        cnt_nxt = cnt;
        unique case (state)
            ST_IDLE: cnt_nxt = cnt;
            ST_LOAD: if (run) cnt_nxt = load_val;
            ST_RUN: begin
                if (run && evt) begin
                    if (cnt == cmp_val) begin
                        cmp_hit = 1'b1;
                        cnt_nxt = load_val;
                    end else if (cnt == CNT_MAX) begin
                        ovf_hit = 1'b1;
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
            end
            default: cnt_nxt = cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              cmp_hit,
    input  logic              ovf_hit,
    input  logic              cmp_ack,
    input  logic              ovf_ack,
    input  logic [CNT_W-1:0]  cnt,
    output logic              run,
    output logic              use_ext,
    output logic              use_pre,
    output logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  cmp_val,
    output logic              cmp_flag,
    output logic              ovf_flag,
    output logic              cmp_irq,
    output logic              ovf_irq
);
    logic ovf_ie, cmp_ie;
    logic ctrl_wr, run_nxt, cmp_clr, ovf_clr;

    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
    assign run_nxt = ctrl_wr ? wr_data[B_RUN] : run;
    assign cmp_clr = (ctrl_wr && wr_data[B_CMP]) || cmp_ack;
    assign ovf_clr = (ctrl_wr && wr_data[B_OVF]) || ovf_ack;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            ovf_ie  <= 1'b0;
            cmp_ie  <= 1'b0;
            use_ext <= 1'b0;
            use_pre <= 1'b0;
        end else if (ctrl_wr) begin
            run     <= wr_data[B_RUN];
            ovf_ie  <= wr_data[B_OVF_IE];
            cmp_ie  <= wr_data[B_CMP_IE];
            use_ext <= wr_data[B_EXT];
            use_pre <= wr_data[B_PRE];
        end
    end

    // hardware set wins over any clear; stopping the timer wipes both
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            cmp_flag <= run_nxt && (cmp_hit || (cmp_flag && !cmp_clr));
            ovf_flag <= run_nxt && (ovf_hit || (ovf_flag && !ovf_clr));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_val <= '0;
            cmp_val  <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_LOAD) load_val <= wr_data[CNT_W-1:0];
            if (wr_addr == A_CMP)  cmp_val  <= wr_data[CNT_W-1:0];
        end
    end

    assign cmp_irq = cmp_flag && cmp_ie;
    assign ovf_irq = ovf_flag && ovf_ie;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: begin
                rd_data[B_RUN]    = run;
                rd_data[B_OVF_IE] = ovf_ie;
                rd_data[B_CMP_IE] = cmp_ie;
                rd_data[B_EXT]    = use_ext;
                rd_data[B_PRE]    = use_pre;
                rd_data[B_OVF]    = ovf_flag;
                rd_data[B_CMP]    = cmp_flag;
            end
            A_LOAD:  rd_data = REG_W'(load_val);
            A_CMP:   rd_data = REG_W'(cmp_val);
            default: rd_data = REG_W'(cnt);
        endcase
    end
endmodule

// File: rtl/evt_cmp_timer.sv
module evt_cmp_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 24,
    parameter int SYNC_ST = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              ext_pin,
    input  logic              pre_tick,
    input  logic              cmp_ack,
    input  logic              ovf_ack,
    output logic              cmp_irq,
    output logic              ovf_irq
);
    logic             run, use_ext, use_pre, evt;
    logic             cmp_hit, ovf_hit, cmp_flag, ovf_flag;
    logic [CNT_W-1:0] cnt, load_val, cmp_val;
    cnt_st_e          state;

    tmr_evt_src #(.SYNC_ST(SYNC_ST)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .use_pre  (use_pre),
        .use_ext  (use_ext),
        .ext_pin  (ext_pin),
        .pre_tick (pre_tick),
        .evt      (evt)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .evt      (evt),
        .load_val (load_val),
        .cmp_val  (cmp_val),
        .cnt      (cnt),
        .cmp_hit  (cmp_hit),
        .ovf_hit  (ovf_hit),
        .state    (state)
    );

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .cmp_hit  (cmp_hit),
        .ovf_hit  (ovf_hit),
        .cmp_ack  (cmp_ack),
        .ovf_ack  (ovf_ack),
        .cnt      (cnt),
        .run      (run),
        .use_ext  (use_ext),
        .use_pre  (use_pre),
        .load_val (load_val),
        .cmp_val  (cmp_val),
        .cmp_flag (cmp_flag),
        .ovf_flag (ovf_flag),
        .cmp_irq  (cmp_irq),
        .ovf_irq  (ovf_irq)
    );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [REG_W-1:0]  wr_data,
    input logic              cmp_ack,
    input logic              ovf_ack,
    input logic              run,
    input cnt_st_e           state,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  load_val,
    input logic              cmp_hit,
    input logic              ovf_hit,
    input logic              cmp_flag,
    input logic              ovf_flag
);
    logic ctrl_wr;
    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

    a_r2_load_on_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && run) |=> (cnt == $past(load_val)));

    a_r3_hit_reloads: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_hit |=> (cnt == $past(load_val)));

    a_r3_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_hit && !ctrl_wr) |=> cmp_flag);

    a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_hit |=> (cnt == '0));

    a_r4_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_hit && !ctrl_wr) |=> ovf_flag);

    a_r3_hits_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmp_hit, ovf_hit}));

    a_r6_cmp_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_ack && !cmp_hit) |=> !cmp_flag);

    a_r6_ovf_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_ack && !ovf_hit) |=> !ovf_flag);

    a_r7_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wr_data[B_RUN]) |=> (!cmp_flag && !ovf_flag));
endmodule

bind evt_cmp_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cmp_ack  (cmp_ack),
    .ovf_ack  (ovf_ack),
    .run      (run),
    .state    (state),
    .cnt      (cnt),
    .load_val (load_val),
    .cmp_hit  (cmp_hit),
    .ovf_hit  (ovf_hit),
    .cmp_flag (cmp_flag),
    .ovf_flag (ovf_flag)
);

// File: tb/test_evt_cmp_timer.sv
`timescale 1ns/1ps
module test_evt_cmp_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [23:0] rd_data;
    logic        ext_pin = 1'b0;
    logic        pre_tick = 1'b0;
    logic        cmp_ack = 1'b0;
    logic        ovf_ack = 1'b0;
    logic        cmp_irq, ovf_irq;

    always #10 clk = ~clk;

    evt_cmp_timer i_evt_cmp_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_pin(ext_pin), .pre_tick(pre_tick), .cmp_ack(cmp_ack),
        .ovf_ack(ovf_ack), .cmp_irq(cmp_irq), .ovf_irq(ovf_irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int cyc = 0;

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_run, m_oie, m_cie, m_ext, m_pre, m_cf, m_of, m_half, p1, p2, p3;
    int m_phase;                         // 0 idle, 1 load, 2 run
    logic [23:0] m_load, m_cmp, m_cnt;

    always @(posedge clk) begin
        bit ev, hc, ho, cwr, run_n, cf_n, of_n;
        logic [23:0] nc;
        int np;
        if (!rst_n) begin
            m_run = 0; m_oie = 0; m_cie = 0; m_ext = 0; m_pre = 0;
            m_cf = 0; m_of = 0; m_half = 0; p1 = 0; p2 = 0; p3 = 0;
            m_phase = 0; m_load = 0; m_cmp = 0; m_cnt = 0;
        end else begin
            ev = m_pre ? pre_tick : (m_ext ? (p2 && !p3) : m_half);
            hc = 0; ho = 0; nc = m_cnt; np = m_phase;
            if (m_phase == 0) begin
                if (m_run) np = 1;
            end else if (m_phase == 1) begin
                if (!m_run) np = 0;
                else begin nc = m_load; np = 2; end
            end else begin
                if (!m_run) np = 0;
                else if (ev) begin
                    if (m_cnt == m_cmp) begin hc = 1; nc = m_load; end
                    else if (m_cnt == 24'hFFFFFF) begin ho = 1; nc = 24'd0; end
                    else nc = m_cnt + 24'd1;
                end
            end
            cwr   = wr_en && (wr_addr == 2'd0);
            run_n = cwr ? wr_data[0] : m_run;
            cf_n  = run_n && (hc || (m_cf && !((cwr && wr_data[21]) || cmp_ack)));
            of_n  = run_n && (ho || (m_of && !((cwr && wr_data[20]) || ovf_ack)));
            m_half = m_run ? !m_half : 1'b0;
            p3 = p2; p2 = p1; p1 = ext_pin;
            m_cnt = nc; m_phase = np; m_cf = cf_n; m_of = of_n;
            if (cwr) begin
                m_run = wr_data[0]; m_oie = wr_data[1]; m_cie = wr_data[2];
                m_ext = wr_data[3]; m_pre = wr_data[15];
            end
            if (wr_en && wr_addr == 2'd1) m_load = wr_data;
            if (wr_en && wr_addr == 2'd2) m_cmp = wr_data;
        end
    end

    function automatic logic [23:0] exp_rd(input logic [1:0] a);
        logic [23:0] v = '0;
        case (a)
            2'd0: begin
                v[0] = m_run; v[1] = m_oie; v[2] = m_cie; v[3] = m_ext;
                v[15] = m_pre; v[20] = m_of; v[21] = m_cf;
            end
            2'd1: v = m_load;
            2'd2: v = m_cmp;
            default: v = m_cnt;
        endcase
        return v;
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            #5;
            chk("R9 cmp_irq vs model", {23'd0, cmp_irq}, {23'd0, m_cf && m_cie});
            chk("R9 ovf_irq vs model", {23'd0, ovf_irq}, {23'd0, m_of && m_oie});
            case (rd_addr)
                2'd0:    chk("R11 control read vs model", rd_data, exp_rd(rd_addr));
                2'd3:    chk("R2 counter read vs model", rd_data, exp_rd(rd_addr));
                default: chk("R12 value read vs model", rd_data, exp_rd(rd_addr));
            endcase
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [1:0] a, input logic [23:0] d);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic tick(input bit ack);
        @(posedge clk); #2;
        pre_tick = 1'b1; cmp_ack = ack;
        @(posedge clk); #2;
        pre_tick = 1'b0; cmp_ack = 1'b0;
    endtask

    task automatic pin_pulse();
        @(posedge clk); #2 ext_pin = 1'b1;
        repeat (3) @(posedge clk);
        #2 ext_pin = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic look(input logic [1:0] a, input string tag, input logic [23:0] exp);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog actual=%0d expected=<100000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        look(2'd0, "R1 control after reset", 24'h0);
        look(2'd1, "R1 start value after reset", 24'h0);
        look(2'd2, "R1 match value after reset", 24'h0);
        look(2'd3, "R1 counter after reset", 24'h0);
        chk("R1 irqs after reset", {22'd0, cmp_irq, ovf_irq}, 24'h0);

        // R2/R3: internal source, N=5, M=9 -> 5 events
        wr(2'd1, 24'd5);
        wr(2'd2, 24'd9);
        wr(2'd0, 24'h000005);
        repeat (2) @(posedge clk);
        look(2'd3, "R2 counter loaded with N", 24'd5);
        repeat (2) @(posedge clk);
        look(2'd3, "R2 first internal event", 24'd6);
        repeat (7) @(posedge clk);
        @(negedge clk); #1;
        chk("R3 no match before event M-N+1", {23'd0, cmp_irq}, 24'd0);
        @(posedge clk);
        @(negedge clk); #1;
        chk("R3 match on event M-N+1", {23'd0, cmp_irq}, 24'd1);
        rd_addr = 2'd3; #1;
        chk("R3 reload to N", rd_data, 24'd5);

        // R5 write-one-to-clear
        wr(2'd0, 24'h000005);
        look(2'd0, "R5 zero write keeps flag", 24'h200005);
        wr(2'd0, 24'h200005);
        look(2'd0, "R5 one write clears flag", 24'h000005);

        // R6 acknowledge clears
        for (int i = 0; i < 40 && !cmp_irq; i++) @(negedge clk);
        @(posedge clk); #2 cmp_ack = 1'b1;
        @(posedge clk); #2 cmp_ack = 1'b0;
        look(2'd0, "R6 ack clears match flag", 24'h000005);

        // R8 set beats clear, prescaler source, N=0, M=2
        wr(2'd0, 24'h0);
        wr(2'd1, 24'd0);
        wr(2'd2, 24'd2);
        wr(2'd0, 24'h008005);
        @(posedge clk);
        tick(0);
        tick(0);
        look(2'd0, "R3 no flag after two of three events", 24'h008005);
        tick(1);
        @(negedge clk); #1;
        chk("R8 set wins over ack", {23'd0, cmp_irq}, 24'd1);

        // R4 wrap
        wr(2'd0, 24'h0);
        wr(2'd1, 24'hFFFFFD);
        wr(2'd2, 24'd1);
        wr(2'd0, 24'h008003);
        @(posedge clk);
        tick(0); tick(0); tick(0);
        look(2'd0, "R4 wrap flag set", 24'h108003);
        look(2'd3, "R4 counter wrapped to zero", 24'd0);
        chk("R9 ovf_irq with enable", {23'd0, ovf_irq}, 24'd1);
        tick(0); tick(0);
        look(2'd0, "R3 match after wrap", 24'h308003);
        look(2'd3, "R3 reload after wrap", 24'hFFFFFD);
        wr(2'd0, 24'h008001);
        look(2'd0, "R9 flags kept with enables off", 24'h308001);
        chk("R9 irqs masked", {22'd0, cmp_irq, ovf_irq}, 24'h0);
        wr(2'd0, 24'h0);
        look(2'd0, "R7 stop clears flags", 24'h0);

        // R10 external pin, then prescaler override
        wr(2'd1, 24'd0);
        wr(2'd2, 24'd100);
        wr(2'd0, 24'h000009);
        repeat (4) @(posedge clk);
        pin_pulse();
        pin_pulse();
        look(2'd3, "R10 one count per pin edge", 24'd2);
        wr(2'd0, 24'h008009);
        pin_pulse();
        look(2'd3, "R10 pin ignored under prescaler", 24'd2);
        tick(0);
        look(2'd3, "R10 prescaler tick counted", 24'd3);

        // R12 map, R11 reserved
        wr(2'd0, 24'h0);
        wr(2'd3, 24'h0000AA);
        look(2'd3, "R12 counter not writable", 24'd3);
        wr(2'd1, 24'h123456);
        look(2'd1, "R12 start value readback", 24'h123456);
        wr(2'd2, 24'h654321);
        look(2'd2, "R12 match value readback", 24'h654321);
        wr(2'd0, 24'hFFFFFF);
        look(2'd0, "R11 reserved bits read zero", 24'h00800F);

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule